// File: doc/BRIEF.md
# Sensor-Extended Intersection Signal Sequencer

This block is a synchronous controller for a single intersection with one north-south approach and a pair of opposing east-west approaches. Each approach has a vehicle-presence bit. The block drives three 2-bit lamp codes: one for north-south and one for each east-west approach. The two east-west lamps are locked together.

The controller steps through a fixed ring of phases. The ring is north-south green, north-south yellow, a one-cycle all-red gap, east-west green, east-west yellow, and a second one-cycle all-red gap. The north-south green runs for a minimum time. After that minimum it is held one more cycle each time the previous cycle saw only the north-south sensor active. All phase timing comes from a single down-counter, which is reloaded whenever a new phase begins. There is no data stream here, so every pin is a plain level signal without a handshake.

Top module: `tlc_top`

## Requirements
- R1: Lamp codes are green = 2'b01, yellow = 2'b10 and red = 2'b11. Outside reset, no lamp output is ever X or Z.
- R2: On every cycle outside reset, `lamp_eb` equals `lamp_wb`.
- R3: When the north-south lamp is green or yellow, both east-west lamps are red. When an east-west lamp is green or yellow, the north-south lamp is red.
- R4: Reset is synchronous and active-high. While reset is held, and on the first cycle after it is released, all lamps are red. The cycle after that shows north-south green.
- R5: East-west green lasts exactly 15 cycles and is followed directly by east-west yellow.
- R6: Yellow lasts exactly 5 cycles in both directions and is followed directly by red.
- R7: North-south green lasts at least 45 cycles, whatever the sensors do.
- R8: Once 45 green cycles have elapsed, north-south green is held for the next cycle only if, in the current cycle, `sens_ns` = 1 and `sens_eb` = `sens_wb` = 0. Otherwise the next cycle is north-south yellow.
- R9: North-south red lasts exactly 22 cycles: one all-red gap, 15 cycles of east-west green, 5 cycles of east-west yellow and a second all-red gap. North-south green follows.
- R10: Every east-west red interval lasts at least 45 cycles.
- R11: Sensor values have no effect during the minimum north-south green, during yellow, during all-red or during east-west green. The lamp sequence is the same for any sensor pattern in those phases.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sens_ns | input | 1 | North-south vehicle present |
| sens_eb | input | 1 | Eastbound vehicle present |
| sens_wb | input | 1 | Westbound vehicle present |
| lamp_ns | output | 2 | North-south lamp code |
| lamp_eb | output | 2 | Eastbound lamp code |
| lamp_wb | output | 2 | Westbound lamp code |

## Verification
Lamp outputs come from a register, so the sensor values present in cycle k show up in the lamps of cycle k+1. The cycle right after reset is released is red, and north-south green appears one cycle later. The bench drives the sensors at each falling edge and checks the lamps at the next falling edge. It steps an arithmetic phase/elapsed-count predictor with exactly the sensor value that the next rising edge will capture. It also measures every completed lamp run and checks its length against the fixed or minimum durations.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef logic [1:0] lamp_t;
  localparam lamp_t LAMP_GREEN  = 2'b01;
  localparam lamp_t LAMP_YELLOW = 2'b10;
  localparam lamp_t LAMP_RED    = 2'b11;

  typedef enum logic [2:0] {
    PH_NS_GO,
    PH_NS_WARN,
    PH_GAP_A,
    PH_EW_GO,
    PH_EW_WARN,
    PH_GAP_B
  } phase_e;
endpackage

// File: rtl/tlc_timer.sv
module tlc_timer #(
  parameter int CW      = 6,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= CW'(RST_VAL);
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);

  // R5: the phase counter steps down by exactly one when no new phase begins
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R7: a freshly loaded count is not already expired unless it was loaded with zero
  a_r7_load_taken: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/tlc_seq.sv
module tlc_seq
  import tlc_pkg::*;
#(
  parameter int NS_MIN = 45,
  parameter int EW_GO  = 15,
  parameter int WARN   = 5,
  parameter int GAP    = 1,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          expired,
  input  logic          sens_ns,
  input  logic          sens_eb,
  input  logic          sens_wb,
  output phase_e        phase,
  output logic          load,
  output logic [CW-1:0] load_val
);
  phase_e nxt;
  logic   ns_only;

  assign ns_only = sens_ns && !sens_eb && !sens_wb;

  function automatic logic [CW-1:0] span_of(input phase_e p);
    case (p)
      PH_NS_GO:   span_of = CW'(NS_MIN - 1);
      PH_EW_GO:   span_of = CW'(EW_GO - 1);
      PH_NS_WARN,
      PH_EW_WARN: span_of = CW'(WARN - 1);
      default:    span_of = CW'(GAP - 1);
    endcase
  endfunction

  always_comb begin
    nxt = phase;
    if (expired) begin
      case (phase)
        PH_NS_GO:   nxt = ns_only ? PH_NS_GO : PH_NS_WARN;
        PH_NS_WARN: nxt = PH_GAP_A;
        PH_GAP_A:   nxt = PH_EW_GO;
        PH_EW_GO:   nxt = PH_EW_WARN;
        PH_EW_WARN: nxt = PH_GAP_B;
        default:    nxt = PH_NS_GO;
      endcase
    end
  end

  assign load     = (nxt != phase);
  assign load_val = span_of(nxt);

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_GAP_B;
    else     phase <= nxt;
  end

  // R8: after the minimum, a lone north-south request holds the green
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_NS_GO && expired && ns_only) |=> (phase == PH_NS_GO));

  // R8: after the minimum, any other sensor pattern ends the green
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_NS_GO && expired && !ns_only) |=> (phase == PH_NS_WARN));

  // R11: before the minimum has elapsed, sensors cannot end the green
  a_r11_min_green: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_NS_GO && !expired) |=> (phase == PH_NS_GO));

  // R6: yellow is followed by an all-red gap
  a_r6_warn_to_red: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_NS_WARN || phase == PH_EW_WARN) && expired) |=>
      (phase == PH_GAP_A || phase == PH_GAP_B));
endmodule

// File: rtl/tlc_lamps.sv
module tlc_lamps
  import tlc_pkg::*;
#(
  parameter int N_EW = 2
) (
  input  phase_e phase,
  output lamp_t  lamp_ns,
  output lamp_t  lamp_ew [N_EW]
);
  lamp_t ew_code;

  always_comb begin
    lamp_ns = LAMP_RED;
    ew_code = LAMP_RED;
    case (phase)
      PH_NS_GO:   lamp_ns = LAMP_GREEN;
      PH_NS_WARN: lamp_ns = LAMP_YELLOW;
      PH_EW_GO:   ew_code = LAMP_GREEN;
      PH_EW_WARN: ew_code = LAMP_YELLOW;
      default:    ;
    endcase
  end

  for (genvar i = 0; i < N_EW; i++) begin : g_ew
    assign lamp_ew[i] = ew_code;
  end
endmodule

// File: rtl/tlc_top.sv
module tlc_top
  import tlc_pkg::*;
#(
  parameter int NS_MIN = 45,
  parameter int EW_GO  = 15,
  parameter int WARN   = 5,
  parameter int GAP    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sens_ns,
  input  logic       sens_eb,
  input  logic       sens_wb,
  output logic [1:0] lamp_ns,
  output logic [1:0] lamp_eb,
  output logic [1:0] lamp_wb
);
  localparam int LONG_A  = (NS_MIN > EW_GO) ? NS_MIN : EW_GO;
  localparam int LONG_B  = (WARN > GAP) ? WARN : GAP;
  localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int CW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  logic          expired;
  logic          load;
  logic [CW-1:0] load_val;
  phase_e        phase;
  lamp_t         ew_lamps [2];

  tlc_timer #(.CW(CW), .RST_VAL(GAP - 1)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  tlc_seq #(
    .NS_MIN(NS_MIN), .EW_GO(EW_GO), .WARN(WARN), .GAP(GAP), .CW(CW)
  ) u_seq (
    .clk(clk), .rst(rst), .expired(expired),
    .sens_ns(sens_ns), .sens_eb(sens_eb), .sens_wb(sens_wb),
    .phase(phase), .load(load), .load_val(load_val)
  );

  tlc_lamps #(.N_EW(2)) u_lamps (
    .phase(phase), .lamp_ns(lamp_ns), .lamp_ew(ew_lamps)
  );

  assign lamp_eb = ew_lamps[0];
  assign lamp_wb = ew_lamps[1];

  // R1: lamp outputs are always known once out of reset
  a_r1_known: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({lamp_ns, lamp_eb, lamp_wb}));

  // R2: the two east-west lamps always agree
  a_r2_ew_match: assert property (@(posedge clk) disable iff (rst)
    lamp_eb == lamp_wb);

  // R3: a moving north-south lamp forces the east-west lamps red
  a_r3_ns_excl: assert property (@(posedge clk) disable iff (rst)
    (lamp_ns != LAMP_RED) |-> (lamp_eb == LAMP_RED && lamp_wb == LAMP_RED));

  // R3: a moving east-west lamp forces the north-south lamp red
  a_r3_ew_excl: assert property (@(posedge clk) disable iff (rst)
    (lamp_eb != LAMP_RED || lamp_wb != LAMP_RED) |-> (lamp_ns == LAMP_RED));

  // R5: east-west green leads straight to east-west yellow
  a_r5_ew_green_next: assert property (@(posedge clk) disable iff (rst)
    (lamp_eb == LAMP_GREEN) |=> (lamp_eb == LAMP_GREEN || lamp_eb == LAMP_YELLOW));
endmodule

// File: tb/tlc_top_test.sv
module tlc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] G = 2'b01, Y = 2'b10, R = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sens_ns = 1'b0, sens_eb = 1'b0, sens_wb = 1'b0;
  logic [1:0] lamp_ns, lamp_eb, lamp_wb;

  int checks = 0;
  int failures = 0;

  int ph, el;
  int first_after;
  logic [1:0] prev_ns, prev_ew;
  int run_ns, run_ew;
  bit valid_ns, valid_ew;
  logic [15:0] lfsr = 16'hACE1;

  tlc_top uut (
    .clk(clk), .rst(rst), .sens_ns(sens_ns), .sens_eb(sens_eb), .sens_wb(sens_wb),
    .lamp_ns(lamp_ns), .lamp_eb(lamp_eb), .lamp_wb(lamp_wb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_ns(input int p);
    return (p == 0) ? G : (p == 1) ? Y : R;
  endfunction

  function automatic logic [1:0] exp_ew(input int p);
    return (p == 3) ? G : (p == 4) ? Y : R;
  endfunction

  function automatic string tag_of(input int p);
    case (p)
      0: return "R8";
      1: return "R6";
      3: return "R5";
      4: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    ph = 5; el = 1; first_after = 2;
    prev_ns = R; prev_ew = R; run_ns = 0; run_ew = 0;
    valid_ns = 1'b0; valid_ew = 1'b0;
  endtask

  // called at a falling edge; s = {ns, eb, wb} applied for the coming rising edge
  task automatic step(input logic [2:0] s);
    string t;
    t = (first_after > 0) ? "R4" : tag_of(ph);
    if (first_after > 0) first_after--;
    chk(!$isunknown({lamp_ns, lamp_eb, lamp_wb}), "R1", int'(lamp_ns), int'(exp_ns(ph)));
    chk(lamp_ns == exp_ns(ph), t, int'(lamp_ns), int'(exp_ns(ph)));
    chk(lamp_eb == exp_ew(ph) && lamp_wb == lamp_eb, "R2", int'({lamp_eb, lamp_wb}),
        int'({exp_ew(ph), exp_ew(ph)}));
    if (lamp_ns != R) chk(lamp_eb == R, "R3", int'(lamp_eb), int'(R));
    // run lengths, north-south
    if (lamp_ns == prev_ns) run_ns++;
    else begin
      if (valid_ns && prev_ns == G) chk(run_ns >= 45, "R7", run_ns, 45);
      if (valid_ns && prev_ns == Y) chk(run_ns == 5, "R6", run_ns, 5);
      if (valid_ns && prev_ns == R) chk(run_ns == 22, "R9", run_ns, 22);
      if (prev_ns != R || valid_ns) valid_ns = 1'b1;
      if (lamp_ns == G) valid_ns = 1'b1;
      prev_ns = lamp_ns; run_ns = 1;
    end
    // run lengths, east-west
    if (lamp_eb == prev_ew) run_ew++;
    else begin
      if (valid_ew && prev_ew == G) chk(run_ew == 15, "R5", run_ew, 15);
      if (valid_ew && prev_ew == Y) chk(run_ew == 5, "R6", run_ew, 5);
      if (valid_ew && prev_ew == R) chk(run_ew >= 45, "R10", run_ew, 45);
      valid_ew = 1'b1;
      prev_ew = lamp_eb; run_ew = 1;
    end
    {sens_ns, sens_eb, sens_wb} = s;
    case (ph)
      0: if (el < 45 || s == 3'b100) el++; else begin ph = 1; el = 1; end
      1: if (el < 5) el++; else begin ph = 2; el = 1; end
      2: begin ph = 3; el = 1; end
      3: if (el < 15) el++; else begin ph = 4; el = 1; end
      4: if (el < 5) el++; else begin ph = 5; el = 1; end
      default: begin ph = 0; el = 1; end
    endcase
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(lamp_ns == R && lamp_eb == R && lamp_wb == R, "R4", int'({lamp_ns, lamp_eb, lamp_wb}), 63);
    rst = 1'b0;
    model_reset();
    // R11 / R8: every sensor combination held for long stretches
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 130; k++) step(3'(c));
    end
    // R11: pseudo-random sensor activity
    for (int k = 0; k < 900; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0]);
    end
    // R4: reset mid-cycle
    rst = 1'b1;
    sens_ns = 1'b1;
    repeat (2) @(negedge clk);
    chk(lamp_ns == R && lamp_eb == R && lamp_wb == R, "R4", int'({lamp_ns, lamp_eb, lamp_wb}), 63);
    rst = 1'b0;
    model_reset();
    // R8: lone north-south request toggling with sparse east-west requests
    for (int k = 0; k < 400; k++) begin
      step({1'b1, (k % 97) == 0, (k % 61) == 0});
    end
    for (int k = 0; k < 150; k++) step(3'b000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule